// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the device side of a two-wire serial link on a data converter. A single output line shows both that a result is ready and the result bits. Power-up and the conversion cadence are timed from an internal clock. When each conversion is due, the block captures the code and the out-of-range flag that the conversion source presents. It then pulls the line low to show that a result is waiting. An external host clocks the result out with a serial clock: the block changes data after each falling edge, and the host samples on the rising edge.

Each result can be read once. Once the last bit has been clocked, the line stays high until the next result arrives. If a result is left unread, or only partly read, the line is forced high for a fixed number of internal cycles before the next result replaces it. This tells the host not to start a transfer while the register is being updated. While the power control is low, the line is released (tristated) and the timers are held at their start values.

Top module: `adc_serial_port`

## Requirements
- R1: While `pwr_on` is low, `dout_oe` is 0. A fall of `pwr_on` sets `dout_oe` to 0 after the next clock edge.
- R2: After `pwr_on` rises, the line is driven high. The first result makes `dout` low exactly PWRUP_CYC+SETTLE_CYC clock edges after the first edge that sees `pwr_on` high.
- R3: Later results make the line go low every PERIOD_CYC clock cycles.
- R4: A frame is 24 bits, most significant first. Bits 23..12 hold the captured code. Bits 11..8 are zero. Then come, in order, a ready bit (0), a zero, the error flag, two identity bits (00) and the check pattern 101.
- R5: The first falling SCLK edge after the line goes low puts bit 23 on the line. Each later falling edge presents the next bit, and the bit is stable at the following rising edge.
- R6: After the 24th rising SCLK edge, the line goes high and stays high. Further SCLK pulses read only ones until the next result.
- R7: When a result has not been fully read, the line is high for exactly GUARD_CYC clock cycles just before the next result makes it low.
- R8: A new result abandons a partly read frame. The next read starts again at bit 23 with the new code.
- R9: SCLK activity while no result is waiting changes neither the line nor the result timing.
- R10: When `pwr_on` returns high after a power-down, the full power-up and settling delay of R2 is timed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power control; low powers the port down |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| res_code | input | CODE_W | Conversion code presented by the source |
| res_err | input | 1 | Out-of-range flag presented by the source |
| dout | output | 1 | Combined ready/data line value |
| dout_oe | output | 1 | Output enable for the line |

## Verification
The bench sweeps 40 codes across the range, including all zeros, all ones and mid-scale, with the error flag toggling. It counts the exact cycle at which each result appears, both after power-up and between results. An off-by-one in either counter would shift those counts. It leaves one result unread, to measure the high window before the update, and it stops another read halfway. A design that kept its bit position across a new result would then shift out a mix of the old and new frames. Extra SCLK pulses after a complete read must return only ones, which catches a port that lets a result be read twice. The bench also drops power in the middle of a frame and then toggles SCLK during the second power-up, so a timer that is not restarted, or a shifter that reacts to idle clocks, shows up.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam logic [7:0] STATUS_BASE = 8'b0000_0101;
  localparam int ERR_POS = 5;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } port_state_t;
endpackage

// File: rtl/adc_sp_sclk_sync.sv
module adc_sp_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], sclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{1'b1}};
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign sclk_rise = sync_q[STAGES-1] & ~prev_q;
  assign sclk_fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_sp_timebase.sv
module adc_sp_timebase #(
  parameter int PWRUP_CYC  = 1000,
  parameter int SETTLE_CYC = 16000,
  parameter int PERIOD_CYC = 8000,
  parameter int GUARD_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic conv_done,
  output logic upd_guard
);
  localparam int FIRST_CYC = PWRUP_CYC + SETTLE_CYC;
  localparam int MAX_CYC   = (FIRST_CYC > PERIOD_CYC) ? FIRST_CYC : PERIOD_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FIRST_LOAD  = CNT_W'(FIRST_CYC - 1);
  localparam logic [CNT_W-1:0] PERIOD_LOAD = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LIM   = CNT_W'(GUARD_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!pwr_on)            cnt_d = FIRST_LOAD;
    else if (cnt_q == '0)   cnt_d = PERIOD_LOAD;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FIRST_LOAD;
    else        cnt_q <= cnt_d;
  end

  assign conv_done = pwr_on && (cnt_q == '0);
  assign upd_guard = pwr_on && (cnt_q <= GUARD_LIM);

  // R3: a completion always falls inside the guard window
  p_done_in_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> upd_guard);

  // R3: completions are never back to back
  p_done_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R10: counter held at the start load while powered down
  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (cnt_q == FIRST_LOAD));
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter
  import adc_sp_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              conv_done,
  input  logic              upd_guard,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_err,
  output logic              dout,
  output logic              dout_oe
);
  localparam int BCNT_W = $clog2(FRAME_W + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_W);

  port_state_t        st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic               bit_q, bit_d;
  logic [FRAME_W-1:0] frame_new;
  logic [7:0]         status;

  always_comb begin
    status          = STATUS_BASE;
    status[ERR_POS] = res_err;
    frame_new = ({{(FRAME_W-CODE_W){1'b0}}, res_code} << (FRAME_W - CODE_W))
              | {{(FRAME_W-8){1'b0}}, status};
  end

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    bit_d  = bit_q;
    if (!pwr_on) begin
      st_d = ST_OFF;
    end else if (conv_done) begin
      st_d   = ST_READY;
      sh_d   = frame_new;
      bcnt_d = '0;
      bit_d  = 1'b1;
    end else if (upd_guard) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_OFF:   st_d = ST_HOLD;
        ST_READY: begin
          if (sclk_fall) begin
            st_d   = ST_SHIFT;
            bit_d  = sh_q[FRAME_W-1];
            sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
            bcnt_d = BCNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (sclk_rise && (bcnt_q == LAST_BIT)) begin
            st_d = ST_HOLD;
          end else if (sclk_fall && (bcnt_q < LAST_BIT)) begin
            bit_d  = sh_q[FRAME_W-1];
            sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      sh_q   <= '0;
      bcnt_q <= '0;
      bit_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      bit_q  <= bit_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_READY: dout = 1'b0;
      ST_SHIFT: dout = bit_q;
      default:  dout = 1'b1;
    endcase
    dout_oe = (st_q != ST_OFF);
  end

  // R1: power control low releases the line one edge later
  p_tristate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !dout_oe);

  // R2: a completion shows as a driven low line on the next cycle
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (dout_oe && !dout));

  // R7: inside the guard window the line is driven high
  p_guard_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_guard && !conv_done) |=> (dout_oe && dout));

  // R4: bit position never runs past the frame length
  p_bcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= LAST_BIT);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int CODE_W      = 12,
  parameter int PWRUP_CYC   = 1000,
  parameter int SETTLE_CYC  = 16000,
  parameter int PERIOD_CYC  = 8000,
  parameter int GUARD_CYC   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              sclk,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_err,
  output logic              dout,
  output logic              dout_oe
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sclk_rise, sclk_fall;
  logic       conv_done, upd_guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_sp_sclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  adc_sp_timebase #(
    .PWRUP_CYC  (PWRUP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .PERIOD_CYC (PERIOD_CYC),
    .GUARD_CYC  (GUARD_CYC)
  ) tb_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwr_on    (pwr_on),
    .conv_done (conv_done),
    .upd_guard (upd_guard)
  );

  adc_sp_shifter #(.CODE_W(CODE_W)) shf_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwr_on    (pwr_on),
    .conv_done (conv_done),
    .upd_guard (upd_guard),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .res_code  (res_code),
    .res_err   (res_err),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );
endmodule

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;
  localparam int PWRUP  = 40;
  localparam int SETTLE = 60;
  localparam int PERIOD = 600;
  localparam int GUARD  = 10;
  localparam int FIRST  = PWRUP + SETTLE;
  localparam int HALF   = 6;

  logic        clk;
  logic        rst_n;
  logic        pwr_on;
  logic        sclk;
  logic [11:0] res_code;
  logic        res_err;
  logic        dout;
  logic        dout_oe;

  int cyc;
  int n_chk;
  int n_bad;

  adc_serial_port #(
    .CODE_W(12), .PWRUP_CYC(PWRUP), .SETTLE_CYC(SETTLE),
    .PERIOD_CYC(PERIOD), .GUARD_CYC(GUARD), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .sclk(sclk),
    .res_code(res_code), .res_err(res_err), .dout(dout), .dout_oe(dout_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_frame(input logic [11:0] c, input logic e);
    return {c, 4'b0000, 1'b0, 1'b0, e, 2'b00, 3'b101};
  endfunction

  // polls each cycle until the line is driven low; optional SCLK wiggle (R9)
  task automatic wait_low(input bit wiggle, output int t);
    int c;
    c = 0;
    while (!(dout_oe && dout == 1'b0)) begin
      if (wiggle) begin
        sclk = (c < 48) ? (((c / HALF) % 2) == 0 ? 1'b0 : 1'b1) : 1'b1;
        if (dout !== 1'b1) check(1'b0, "R9", dout, 1);
      end
      c++;
      @(negedge clk);
    end
    sclk = 1'b1;
    t = cyc;
  endtask

  task automatic read_bits(input int nbits, output logic [23:0] got);
    got = '1;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      got[23-i] = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    logic [23:0] got, exp;
    logic [11:0] cur_code;
    logic        cur_err;
    int t0, t, tprev, n;
    cyc = 0; n_chk = 0; n_bad = 0;
    rst_n = 1'b0; pwr_on = 1'b0; sclk = 1'b1;
    res_code = 12'h000; res_err = 1'b0;
    repeat (4) @(negedge clk);
    check(dout_oe == 1'b0, "R1 reset", dout_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(dout_oe == 1'b0, "R1 off", dout_oe, 0);

    pwr_on = 1'b1;
    t0 = cyc;
    @(negedge clk);
    check(dout_oe && dout, "R2 high after power-on", {dout_oe, dout}, 3);
    wait_low(1'b0, t);
    check(t - t0 == FIRST, "R2 first result", t - t0, FIRST);
    tprev = t;

    // sweep of codes (R3 R4 R5 R6)
    for (int k = 0; k < 40; k++) begin
      if (k > 0) begin
        wait_low(1'b0, t);
        check(t - tprev == PERIOD, "R3 cadence", t - tprev, PERIOD);
        tprev = t;
      end
      cur_code = res_code; cur_err = res_err;
      exp = exp_frame(cur_code, cur_err);
      res_code = (k == 0) ? 12'hFFF : (k == 1) ? 12'h800 : 12'((k * 173 + 5) % 4096);
      res_err  = k[0] ^ k[2];
      read_bits(24, got);
      check(got == exp, "R4 R5 frame", got, exp);
      repeat (3) @(negedge clk);
      check(dout_oe && dout, "R6 high after read", dout, 1);
      if (k % 5 == 2) begin
        read_bits(3, got);
        check(got == 24'hFFFFFF, "R6 second read", got, 24'hFFFFFF);
      end
    end

    // unread result: guard window (R7) then new result (R8)
    wait_low(1'b0, t);
    tprev = t;
    res_code = 12'h3C5; res_err = 1'b1;
    n = 0;
    while (dout == 1'b0) begin n++; @(negedge clk); end
    check(n == PERIOD - GUARD, "R7 low hold", n, PERIOD - GUARD);
    n = 0;
    while (dout == 1'b1) begin n++; @(negedge clk); end
    check(n == GUARD, "R7 guard width", n, GUARD);
    t = cyc;
    check(t - tprev == PERIOD, "R3 cadence unread", t - tprev, PERIOD);
    tprev = t;
    res_code = 12'h0A7; res_err = 1'b0;
    read_bits(24, got);
    exp = exp_frame(12'h3C5, 1'b1);
    check(got == exp, "R8 fresh frame after unread", got, exp);

    // partial read then preemption (R8)
    wait_low(1'b0, t);
    check(t - tprev == PERIOD, "R3 cadence", t - tprev, PERIOD);
    tprev = t;
    res_code = 12'h555; res_err = 1'b1;
    read_bits(10, got);
    exp = exp_frame(12'h0A7, 1'b0);
    check(got[23:14] == exp[23:14], "R8 partial bits", got[23:14], exp[23:14]);
    while (dout == 1'b0) @(negedge clk);
    while (dout == 1'b1) @(negedge clk);
    t = cyc;
    check(t - tprev == PERIOD, "R8 preempt timing", t - tprev, PERIOD);
    read_bits(24, got);
    exp = exp_frame(12'h555, 1'b1);
    check(got == exp, "R8 restart at msb", got, exp);

    // power down mid-frame (R1 R10), wiggle SCLK during power-up (R9)
    wait_low(1'b0, t);
    res_code = 12'h123; res_err = 1'b0;
    read_bits(5, got);
    pwr_on = 1'b0;
    @(negedge clk);
    check(dout_oe == 1'b0, "R1 power-down mid-frame", dout_oe, 0);
    repeat (20) @(negedge clk);
    check(dout_oe == 1'b0, "R1 stays off", dout_oe, 0);
    pwr_on = 1'b1;
    t0 = cyc;
    @(negedge clk);
    wait_low(1'b1, t);
    check(t - t0 == FIRST, "R10 R9 power-up restart", t - t0, FIRST);
    read_bits(24, got);
    exp = exp_frame(12'h123, 1'b0);
    check(got == exp, "R10 frame after restart", got, exp);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule